// File: doc/BRIEF.md
# Mode-Banked CPU Register File

This block is the general register file of a processor core that runs in seven operating modes. Software sees sixteen 32-bit registers, but some of them have private copies per mode. Registers 8 to 12 have one extra copy for the fast-interrupt mode. Registers 13 and 14 have one copy per exception mode, and User and System share a single copy. Each exception mode also has a saved status word. A mode change, whether it comes from a request or from a write to the status word, makes the new mode's copies the ones that are visible.

The datapath reads through two combinational ports and writes through one port. A second path, the user view, lets privileged code read or write the copy that User mode would see. The block holds the current status word, which resets to System mode with all flags clear. A mode encoding that is not valid is refused and sets a sticky error flag.

Top module: `rbk_regfile`

## Requirements
- R1: After reset the status word reads 0x0000001F (System mode), the saved-status port reads 0, every register reads 0 and both error outputs are low.
- R2: Both read ports show the live copy of the addressed register for the current mode, without a clock. A write through the main port becomes visible from the next clock edge.
- R3: Registers 0 to 7 and register 15 are a single copy shared by every mode.
- R4: Registers 8 to 12 have one copy used only in fast-interrupt mode (10001) and a second copy used by all other modes.
- R5: Registers 13 and 14 have six copies: User (10000) and System (11111) share one, and Supervisor (10011), Abort (10111), Undefined (11011), Irq (10010) and fast-interrupt (10001) have one each.
- R6: Each of the five exception modes has its own saved status word. In User or System the saved-status port reads 0, and a saved-status write there is ignored and raises saved_err_o in the same cycle.
- R7: A valid mode request takes one clock. Reads in the request cycle see the old mode's copies and reads in the next cycle see the new mode's copies. Status bits [4:0] take the new mode and bits [31:5] are kept.
- R8: A status write stores the whole word. If its bits [4:0] name another mode, the banked copies switch to that mode. If the field is unchanged, the visible copies stay the same.
- R9: A mode request or status write whose 5-bit mode field is not one of the seven encodings sets mode_err_o from the next cycle until reset. Nothing is written in that cycle: status, registers and saved status all keep their values.
- R10: A user-view access maps registers 8 to 12 to the non-fast-interrupt copy, registers 13 and 14 to the shared User/System copy, and registers 0 to 7 and 15 to the live registers.
- R11: A register or saved-status write in the same cycle as a mode change goes to the copy of the old mode.
- R12: When a main-port write and a user-view write hit the same physical register in one cycle, the main-port value is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | DATA_W | Read port A value |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | DATA_W | Read port B value |
| wr_en | input | 1 | Main write enable |
| wr_idx | input | 4 | Main write register number |
| wr_data | input | DATA_W | Main write value |
| uv_rd_idx | input | 4 | User-view read register number |
| uv_rd_data | output | DATA_W | User-view read value |
| uv_wr_en | input | 1 | User-view write enable |
| uv_wr_idx | input | 4 | User-view write register number |
| uv_wr_data | input | DATA_W | User-view write value |
| mode_req | input | 1 | Request a mode change |
| mode_new | input | 5 | Mode carried by the request |
| stat_wr_en | input | 1 | Write the status word (ignored while mode_req is high) |
| stat_wr_data | input | 32 | Status word to store |
| stat_o | output | 32 | Current status word |
| saved_wr_en | input | 1 | Write the saved status of the current mode |
| saved_wr_data | input | 32 | Saved status value |
| saved_o | output | 32 | Saved status of the current mode, 0 if none |
| saved_err_o | output | 1 | Saved-status write attempted in User or System |
| mode_err_o | output | 1 | Sticky invalid-mode flag |

## Verification
A table of mode and register pairs writes distinct values to each class of register in different modes and then reads them back from other modes. A wrongly merged or wrongly split bank therefore shows up as a foreign value or a missing one. Directed cases follow the table. They check a same-cycle read against a next-cycle read around a mode change, a status write that keeps the mode field against one that changes it, and user-view accesses from fast-interrupt mode that must miss that mode's private copies. They also cover a write that coincides with a mode change, two writes that collide on one register, and invalid mode fields from both sources.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

    localparam int RIDX_W   = 4;
    localparam int MODE_W   = 5;
    localparam int STAT_W   = 32;
    localparam int N_LOW    = 8;
    localparam int N_FBANK  = 5;
    localparam int N_SLOT   = 6;
    localparam int N_SAVED  = 5;
    localparam int FIQ_BASE = N_LOW;
    localparam int STK_BASE = FIQ_BASE + 2 * N_FBANK;
    localparam int PC_PHYS  = STK_BASE + 2 * N_SLOT;
    localparam int NPHYS    = PC_PHYS + 1;
    localparam int PHYS_W   = $clog2(NPHYS);
    localparam int SLOT_W   = $clog2(N_SLOT);
    localparam logic [STAT_W-1:0] STAT_RST = 32'h0000_001F;

    typedef enum logic [MODE_W-1:0] {
        MD_USR = 5'b10000,
        MD_FIQ = 5'b10001,
        MD_IRQ = 5'b10010,
        MD_SVC = 5'b10011,
        MD_ABT = 5'b10111,
        MD_UND = 5'b11011,
        MD_SYS = 5'b11111
    } cpu_mode_e;

    function automatic logic mode_ok(logic [MODE_W-1:0] m);
        case (m)
            MD_USR, MD_FIQ, MD_IRQ, MD_SVC,
            MD_ABT, MD_UND, MD_SYS: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

    function automatic logic has_saved(logic [MODE_W-1:0] m);
        case (m)
            MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND: return 1'b1;
            default:                               return 1'b0;
        endcase
    endfunction

    // stack-pair slot: 0 is shared by User and System
    function automatic logic [SLOT_W-1:0] stack_slot(logic [MODE_W-1:0] m);
        case (m)
            MD_SVC:  return SLOT_W'(1);
            MD_ABT:  return SLOT_W'(2);
            MD_UND:  return SLOT_W'(3);
            MD_IRQ:  return SLOT_W'(4);
            MD_FIQ:  return SLOT_W'(5);
            default: return SLOT_W'(0);
        endcase
    endfunction

    function automatic int saved_slot(logic [MODE_W-1:0] m);
        case (m)
            MD_SVC:  return 0;
            MD_ABT:  return 1;
            MD_UND:  return 2;
            MD_IRQ:  return 3;
            default: return 4;
        endcase
    endfunction

    // logical register + mode + user-view -> physical storage index
    function automatic logic [PHYS_W-1:0] phys_of(logic [RIDX_W-1:0] r,
                                                  logic [MODE_W-1:0] m,
                                                  logic uv);
        int p;
        if (int'(r) < N_LOW)
            p = int'(r);
        else if (r == 4'd15)
            p = PC_PHYS;
        else if (int'(r) < N_LOW + N_FBANK)
            p = FIQ_BASE + 2 * (int'(r) - N_LOW) + ((m == MD_FIQ && !uv) ? 1 : 0);
        else
            p = STK_BASE + 2 * (uv ? 0 : int'(stack_slot(m))) + (int'(r) - 13);
        return PHYS_W'(p);
    endfunction

endpackage

// File: rtl/rbk_mapper.sv
module rbk_mapper
    import rbk_pkg::*;
#(
    parameter int NLANE = 5
) (
    input  logic [MODE_W-1:0]             mode,
    input  logic [NLANE-1:0][RIDX_W-1:0]  lane_reg,
    input  logic [NLANE-1:0]              lane_uv,
    output logic [NLANE-1:0][PHYS_W-1:0]  lane_phys
);

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_phys[g] = phys_of(lane_reg[g], mode, lane_uv[g]);
    end

endmodule

// File: rtl/rbk_store.sv
module rbk_store
    import rbk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NRD    = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            w0_en,
    input  logic [PHYS_W-1:0]               w0_idx,
    input  logic [DATA_W-1:0]               w0_data,
    input  logic                            w1_en,
    input  logic [PHYS_W-1:0]               w1_idx,
    input  logic [DATA_W-1:0]               w1_data,
    input  logic [NRD-1:0][PHYS_W-1:0]      r_idx,
    output logic [NRD-1:0][DATA_W-1:0]      r_data
);

    logic [DATA_W-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else begin
            // port 0 is assigned last so it wins a collision
            if (w1_en) mem[w1_idx] <= w1_data;
            if (w0_en) mem[w0_idx] <= w0_data;
        end
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign r_data[k] = mem[r_idx[k]];
    end

endmodule

// File: rtl/rbk_saved.sv
module rbk_saved
    import rbk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [MODE_W-1:0]  mode,
    input  logic               wr_req,
    input  logic               commit,
    input  logic [STAT_W-1:0]  wr_data,
    output logic [STAT_W-1:0]  rd_data,
    output logic               err
);

    logic [STAT_W-1:0] slot_q [N_SAVED];
    logic              present;

    assign present = has_saved(mode);
    assign err     = wr_req && !present;
    assign rd_data = present ? slot_q[saved_slot(mode)] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SAVED; i++) slot_q[i] <= '0;
        end else if (wr_req && commit && present) begin
            slot_q[saved_slot(mode)] <= wr_data;
        end
    end

endmodule

// File: rtl/rbk_regfile.sv
module rbk_regfile
    import rbk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         rd_a_idx,
    output logic [DATA_W-1:0]  rd_a_data,
    input  logic [3:0]         rd_b_idx,
    output logic [DATA_W-1:0]  rd_b_data,
    input  logic               wr_en,
    input  logic [3:0]         wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [3:0]         uv_rd_idx,
    output logic [DATA_W-1:0]  uv_rd_data,
    input  logic               uv_wr_en,
    input  logic [3:0]         uv_wr_idx,
    input  logic [DATA_W-1:0]  uv_wr_data,
    input  logic               mode_req,
    input  logic [4:0]         mode_new,
    input  logic               stat_wr_en,
    input  logic [31:0]        stat_wr_data,
    output logic [31:0]        stat_o,
    input  logic               saved_wr_en,
    input  logic [31:0]        saved_wr_data,
    output logic [31:0]        saved_o,
    output logic               saved_err_o,
    output logic               mode_err_o
);

    localparam int NLANE = 5;
    localparam int NRD   = 3;

    logic [STAT_W-1:0] stat_q;
    logic              err_q;
    logic [MODE_W-1:0] cur_mode;
    logic              bad_req;
    logic              commit;

    assign cur_mode = stat_q[MODE_W-1:0];

    // invalid field from either source blocks every update this cycle
    assign bad_req = mode_req ? !mode_ok(mode_new)
                              : (stat_wr_en && !mode_ok(stat_wr_data[MODE_W-1:0]));
    assign commit  = !bad_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= STAT_RST;
            err_q  <= 1'b0;
        end else if (bad_req) begin
            err_q  <= 1'b1;
        end else if (mode_req) begin
            stat_q[MODE_W-1:0] <= mode_new;
        end else if (stat_wr_en) begin
            stat_q <= stat_wr_data;
        end
    end

    // lanes: 0 read A, 1 read B, 2 main write, 3 user-view read, 4 user-view write
    logic [NLANE-1:0][RIDX_W-1:0] lane_reg;
    logic [NLANE-1:0]             lane_uv;
    logic [NLANE-1:0][PHYS_W-1:0] lane_phys;

    assign lane_reg = {uv_wr_idx, uv_rd_idx, wr_idx, rd_b_idx, rd_a_idx};
    assign lane_uv  = 5'b11000;

    rbk_mapper #(.NLANE(NLANE)) u_map (
        .mode      (cur_mode),
        .lane_reg  (lane_reg),
        .lane_uv   (lane_uv),
        .lane_phys (lane_phys)
    );

    logic [NRD-1:0][PHYS_W-1:0] rd_phys;
    logic [NRD-1:0][DATA_W-1:0] rd_val;

    assign rd_phys = {lane_phys[3], lane_phys[1], lane_phys[0]};

    rbk_store #(.DATA_W(DATA_W), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .w0_en   (wr_en && commit),
        .w0_idx  (lane_phys[2]),
        .w0_data (wr_data),
        .w1_en   (uv_wr_en && commit),
        .w1_idx  (lane_phys[4]),
        .w1_data (uv_wr_data),
        .r_idx   (rd_phys),
        .r_data  (rd_val)
    );

    assign rd_a_data  = rd_val[0];
    assign rd_b_data  = rd_val[1];
    assign uv_rd_data = rd_val[2];

    rbk_saved u_saved (
        .clk     (clk),
        .rst     (rst),
        .mode    (cur_mode),
        .wr_req  (saved_wr_en),
        .commit  (commit),
        .wr_data (saved_wr_data),
        .rd_data (saved_o),
        .err     (saved_err_o)
    );

    assign stat_o     = stat_q;
    assign mode_err_o = err_q;

endmodule

// File: rtl/rbk_regfile_chk.sv
module rbk_regfile_chk
    import rbk_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        mode_req,
    input logic [4:0]  mode_new,
    input logic [31:0] stat_o,
    input logic [31:0] saved_o,
    input logic        saved_err_o,
    input logic        mode_err_o
);

    // R9
    mode_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mode_err_o |=> mode_err_o);

    // R9
    bad_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_req && !mode_ok(mode_new)) |=> ($stable(stat_o) && mode_err_o));

    // R7
    mode_load_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_req && mode_ok(mode_new)) |=>
            (stat_o[4:0] == $past(mode_new) && stat_o[31:5] == $past(stat_o[31:5])));

    // R6
    saved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !has_saved(stat_o[4:0]) |-> (saved_o == 32'h0));

    // R6
    saved_err_chk: assert property (@(posedge clk) disable iff (rst)
        saved_err_o |-> !has_saved(stat_o[4:0]));

    // R1
    stat_valid_chk: assert property (@(posedge clk) disable iff (rst)
        mode_ok(stat_o[4:0]));

endmodule

bind rbk_regfile rbk_regfile_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_req    (mode_req),
    .mode_new    (mode_new),
    .stat_o      (stat_o),
    .saved_o     (saved_o),
    .saved_err_o (saved_err_o),
    .mode_err_o  (mode_err_o)
);

// File: tb/rbk_regfile_test.sv
module rbk_regfile_test;

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111;
    localparam int NVEC = 21;

    // {mode, reg, is_write, value}
    localparam logic [41:0] VEC [NVEC] = '{
        {SYS, 4'd8,  1'b1, 32'h11},
        {FIQ, 4'd8,  1'b1, 32'h22},
        {SYS, 4'd8,  1'b0, 32'h11},  // R4
        {FIQ, 4'd8,  1'b0, 32'h22},  // R4
        {IRQ, 4'd8,  1'b0, 32'h11},  // R4
        {SYS, 4'd13, 1'b1, 32'h33},
        {SVC, 4'd13, 1'b1, 32'h44},
        {ABT, 4'd13, 1'b1, 32'h55},
        {USR, 4'd13, 1'b0, 32'h33},  // R5 shared slot
        {SVC, 4'd13, 1'b0, 32'h44},  // R5
        {ABT, 4'd14, 1'b1, 32'h66},
        {UND, 4'd13, 1'b0, 32'h0},   // R5 untouched slot
        {ABT, 4'd13, 1'b0, 32'h55},  // R5
        {FIQ, 4'd3,  1'b1, 32'h77},
        {USR, 4'd3,  1'b0, 32'h77},  // R3
        {IRQ, 4'd15, 1'b1, 32'h88},
        {FIQ, 4'd15, 1'b0, 32'h88},  // R3
        {ABT, 4'd14, 1'b0, 32'h66},  // R5
        {FIQ, 4'd12, 1'b1, 32'h99},
        {UND, 4'd12, 1'b0, 32'h0},   // R4
        {FIQ, 4'd12, 1'b0, 32'h99}   // R4
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, uv_rd_idx = '0, uv_wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, uv_rd_data;
    logic        wr_en = 1'b0, uv_wr_en = 1'b0;
    logic [31:0] wr_data = '0, uv_wr_data = '0;
    logic        mode_req = 1'b0;
    logic [4:0]  mode_new = '0;
    logic        stat_wr_en = 1'b0;
    logic [31:0] stat_wr_data = '0;
    logic [31:0] stat_o;
    logic        saved_wr_en = 1'b0;
    logic [31:0] saved_wr_data = '0;
    logic [31:0] saved_o;
    logic        saved_err_o, mode_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rbk_regfile uut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .uv_rd_idx(uv_rd_idx), .uv_rd_data(uv_rd_data),
        .uv_wr_en(uv_wr_en), .uv_wr_idx(uv_wr_idx), .uv_wr_data(uv_wr_data),
        .mode_req(mode_req), .mode_new(mode_new),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .stat_o(stat_o),
        .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data), .saved_o(saved_o),
        .saved_err_o(saved_err_o), .mode_err_o(mode_err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic go_mode(input logic [4:0] m);
        @(negedge clk); mode_req = 1'b1; mode_new = m;
        @(negedge clk); mode_req = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] r, input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; wr_idx = r; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic uv_wr(input logic [3:0] r, input logic [31:0] v);
        @(negedge clk); uv_wr_en = 1'b1; uv_wr_idx = r; uv_wr_data = v;
        @(negedge clk); uv_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] r, output logic [31:0] v);
        rd_a_idx = r; #1; v = rd_a_data;
    endtask

    task automatic uv_rd(input logic [3:0] r, output logic [31:0] v);
        uv_rd_idx = r; #1; v = uv_rd_data;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", stat_o, 32'h0000_001F);
        chk("R1 saved", saved_o, 32'h0);
        chk("R1 mode_err", {31'b0, mode_err_o}, 32'h0);
        chk("R1 saved_err", {31'b0, saved_err_o}, 32'h0);
        rd(4'd5, got); chk("R1 r5", got, 32'h0);
        rd_b_idx = 4'd14; #1; chk("R1 r14 port B", rd_b_data, 32'h0);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            go_mode(VEC[i][41:37]);
            if (VEC[i][32]) begin
                wr_reg(VEC[i][36:33], VEC[i][31:0]);
            end else begin
                rd(VEC[i][36:33], got);
                chk($sformatf("R2 table entry %0d", i), got, VEC[i][31:0]);
            end
        end

        // R8 status write keeping the mode field (FIQ)
        @(negedge clk); stat_wr_en = 1'b1; stat_wr_data = 32'hA000_0011;
        @(negedge clk); stat_wr_en = 1'b0;
        chk("R8 same-field status", stat_o, 32'hA000_0011);
        rd(4'd8, got); chk("R8 same-field bank", got, 32'h22);

        // R7 one-cycle mode change
        @(negedge clk); mode_req = 1'b1; mode_new = SVC; rd_a_idx = 4'd13; #1;
        chk("R7 old view same cycle", rd_a_data, 32'h0);
        @(negedge clk); mode_req = 1'b0; #1;
        chk("R7 new view next cycle", rd_a_data, 32'h44);
        chk("R7 status kept flags", stat_o, 32'hA000_0013);

        // R8 status write changing the mode field
        @(negedge clk); stat_wr_en = 1'b1; stat_wr_data = 32'hA000_0017;
        @(negedge clk); stat_wr_en = 1'b0;
        rd(4'd13, got); chk("R8 swap to abort r13", got, 32'h55);
        chk("R8 status stored", stat_o, 32'hA000_0017);

        // R6 saved status
        @(negedge clk); saved_wr_en = 1'b1; saved_wr_data = 32'h0000_1234;
        @(negedge clk); saved_wr_en = 1'b0; #1;
        chk("R6 abort saved", saved_o, 32'h0000_1234);
        go_mode(UND); #1; chk("R6 undefined saved", saved_o, 32'h0);
        go_mode(ABT); #1; chk("R6 abort saved again", saved_o, 32'h0000_1234);
        go_mode(USR); #1; chk("R6 user saved", saved_o, 32'h0);
        @(negedge clk); saved_wr_en = 1'b1; saved_wr_data = 32'h0000_DEAD; #1;
        chk("R6 saved_err", {31'b0, saved_err_o}, 32'h1);
        @(negedge clk); saved_wr_en = 1'b0; #1;
        chk("R6 user saved after write", saved_o, 32'h0);
        go_mode(ABT); #1; chk("R6 abort saved kept", saved_o, 32'h0000_1234);
        go_mode(SYS); #1; chk("R6 system saved", saved_o, 32'h0);

        // R10 user view from fast-interrupt mode
        go_mode(FIQ);
        uv_rd(4'd8, got);  chk("R10 uv r8", got, 32'h11);
        uv_rd(4'd13, got); chk("R10 uv r13", got, 32'h33);
        uv_rd(4'd3, got);  chk("R10 uv r3", got, 32'h77);
        uv_wr(4'd14, 32'hAB);
        uv_wr(4'd9, 32'hCD);
        rd(4'd9, got);  chk("R10 fiq r9 untouched", got, 32'h0);
        rd(4'd14, got); chk("R10 fiq r14 untouched", got, 32'h0);
        go_mode(SYS);
        rd(4'd14, got); chk("R10 system r14", got, 32'hAB);
        rd(4'd9, got);  chk("R10 system r9", got, 32'hCD);

        // R11 write coinciding with a mode change
        go_mode(SVC);
        @(negedge clk); mode_req = 1'b1; mode_new = IRQ;
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h5A;
        @(negedge clk); mode_req = 1'b0; wr_en = 1'b0;
        rd(4'd13, got); chk("R11 irq r13 untouched", got, 32'h0);
        go_mode(SVC);
        rd(4'd13, got); chk("R11 supervisor r13", got, 32'h5A);

        // R12 collision
        go_mode(SYS);
        @(negedge clk); wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h1;
        uv_wr_en = 1'b1; uv_wr_idx = 4'd14; uv_wr_data = 32'h2;
        @(negedge clk); wr_en = 1'b0; uv_wr_en = 1'b0;
        rd_b_idx = 4'd14; #1; chk("R12 collision port B", rd_b_data, 32'h1);

        // R9 invalid mode fields
        chk("R9 no error yet", {31'b0, mode_err_o}, 32'h0);
        @(negedge clk); mode_req = 1'b1; mode_new = 5'b00000;
        wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'hEE;
        @(negedge clk); mode_req = 1'b0; wr_en = 1'b0; #1;
        chk("R9 error raised", {31'b0, mode_err_o}, 32'h1);
        chk("R9 status held", stat_o, 32'hA000_001F);
        rd(4'd0, got); chk("R9 write dropped", got, 32'h0);
        @(negedge clk); stat_wr_en = 1'b1; stat_wr_data = 32'h0000_0015;
        @(negedge clk); stat_wr_en = 1'b0; #1;
        chk("R9 bad status write held", stat_o, 32'hA000_001F);
        go_mode(USR); #1;
        chk("R9 valid after error", stat_o, 32'hA000_0010);
        chk("R9 error sticky", {31'b0, mode_err_o}, 32'h1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule